// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block walks a serial link controller through its speed bring-up. On a start pulse it limits the controller to first-generation speed and then enables training. It waits for the link to come up. If the requested target is second generation, it then widens the allowed speed and asks the controller for a directed speed change. It waits for that change to finish, unless the variant input says the completion flag cannot be trusted. It checks link-up a second time and reads back the negotiated generation.

The controller is reached through a simple register port. A read returns its data in the cycle after the request. Any timeout sends the sequencer through a recovery step on the PHY's indirect access port: it sets two receiver override bits, holds them for a programmable time, then clears them again. The result (success or failure, and the generation) stays on the outputs until the next start.

Top module: `link_speed_seq`

## Requirements
- R1: After start, the first register access reads the capability register. The next access writes it back with bits 3:0 (the maximum-speed field) set to 1 and every other bit unchanged. `train_en` rises only after that write.
- R2: If `link_up` stays low for LINK_TO cycles during the first training wait, the sequence fails. No further capability write is made and no speed-control write is made.
- R3: With `target_gen` = 1, the sequencer reads the status register right after the first link-up and reports success. It never writes the speed-control register.
- R4: With `target_gen` = 2, after the first link-up the capability register is rewritten by read-modify-write with bits 3:0 = 2. Then the speed-control register is read and written back with bit 17 set and all other bits kept.
- R5: After that write, the speed-control register is polled with POLL_GAP idle cycles before each read, until bit 17 reads 0. After POLLS reads that all show bit 17 set, the sequence fails.
- R6: When `skip_chg_wait` is 1 at start, no completion polls are made: there is exactly one speed-control read in the whole sequence.
- R7: After the speed change, `link_up` must be seen again within LINK_TO cycles, or the sequence fails.
- R8: On success, `link_gen` equals bits 19:16 of the status register as read at the end of the sequence.
- R9: On failure, the PHY register at address 0x1005 is read and written back with bits 5 and 3 set. After at least HOLD cycles it is read again and written back with those bits cleared. Only then does `done_fail` rise. Each PHY request holds its controls stable until `phy_ack`.
- R10: `done_ok` and `done_fail` are never high together. Both clear when a sequence starts and stay low while `busy`. A start pulse while busy is ignored.
- R11: After reset, `busy`, `train_en`, `done_ok`, `done_fail`, `reg_req`, `phy_req` and `link_gen` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| target_gen | input | 2 | Requested final generation (1 or 2) |
| skip_chg_wait | input | 1 | Skip the speed-change completion poll |
| link_up | input | 1 | Link trained indication from the controller |
| reg_req | output | 1 | Register access strobe, one cycle |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Read data, valid the cycle after a read strobe |
| phy_req | output | 1 | PHY indirect access request, held until ack |
| phy_we | output | 1 | PHY access is a write |
| phy_addr | output | PHY_AW | PHY register address |
| phy_wdata | output | PHY_DW | PHY write data |
| phy_rdata | input | PHY_DW | PHY read data, valid with ack |
| phy_ack | input | 1 | PHY access complete |
| train_en | output | 1 | Link training enable |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Sequence succeeded (held) |
| done_fail | output | 1 | Sequence failed (held) |
| link_gen | output | 4 | Negotiated generation on success |

## Verification
A wrong state transition shows at the register or PHY port within a few cycles. A skipped read-modify-write leaves the wrong value in the model's capability or speed-control log. A lost timeout makes the run never reach a result. A mis-steered branch produces either a speed-control write that should not exist or a missing one. Counter faults show up as the wrong number of completion polls, or as a recovery hold shorter than HOLD cycles, both measured in the model as soon as the failing sequence ends.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_CAP_RD,
        S_CAP_CAP,
        S_CAP_WR,
        S_LINK1,
        S_CAP2_RD,
        S_CAP2_CAP,
        S_CAP2_WR,
        S_SPD_RD,
        S_SPD_CAP,
        S_SPD_WR,
        S_GAP,
        S_POLL_RD,
        S_POLL_CAP,
        S_LINK2,
        S_STS_RD,
        S_STS_CAP,
        S_PHY_RD1,
        S_PHY_WR1,
        S_HOLD,
        S_PHY_RD2,
        S_PHY_WR2
    } seq_st_e;

endpackage

// File: rtl/lsq_counter.sv
module lsq_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/lsq_rmw.sv
module lsq_rmw #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] nxt
);
    always_comb nxt = (cur & ~clr_mask) | set_bits;
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
    import lsq_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter int              ADDR_W     = 12,
    parameter logic [11:0]     CAP_ADDR   = 12'h010,
    parameter logic [11:0]     SPD_ADDR   = 12'h014,
    parameter logic [11:0]     STS_ADDR   = 12'h018,
    parameter int              PHY_AW     = 16,
    parameter int              PHY_DW     = 16,
    parameter logic [15:0]     PHY_RX_REG = 16'h1005,
    parameter int              LINK_TO    = 4096,
    parameter int              POLLS      = 200,
    parameter int              POLL_GAP   = 25000,
    parameter int              HOLD       = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        target_gen,
    input  logic              skip_chg_wait,
    input  logic              link_up,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    input  logic [PHY_DW-1:0] phy_rdata,
    input  logic              phy_ack,
    output logic              train_en,
    output logic              busy,
    output logic              done_ok,
    output logic              done_fail,
    output logic [3:0]        link_gen
);
    // Field positions decoded by the controller and the PHY
    localparam int SPD_FIELD_W = 4;
    localparam int CHG_BIT     = 17;
    localparam int GEN_LSB     = 16;
    localparam int RX_DATA_BIT = 5;
    localparam int RX_PLL_BIT  = 3;
    localparam int NUM_GENS    = 2;

    localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((1 << SPD_FIELD_W) - 1);
    localparam logic [DATA_W-1:0] CHG_MASK   = DATA_W'(1) << CHG_BIT;
    localparam logic [PHY_DW-1:0] RX_MASK    =
        (PHY_DW'(1) << RX_DATA_BIT) | (PHY_DW'(1) << RX_PLL_BIT);

    localparam int TMR_MAX0 = (LINK_TO > POLL_GAP) ? LINK_TO : POLL_GAP;
    localparam int TMR_MAX  = (TMR_MAX0 > HOLD) ? TMR_MAX0 : HOLD;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int PC_W     = $clog2(POLLS + 1);

    localparam logic [TMR_W-1:0] LINK_LAST = TMR_W'(LINK_TO - 1);
    localparam logic [TMR_W-1:0] GAP_LAST  = TMR_W'(POLL_GAP - 1);
    localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD - 1);
    localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(POLLS - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [DATA_W-1:0] shadow;
        logic [3:0]        gen;
        logic              ok;
        logic              fail;
        logic              train;
        logic              tgt2;
        logic              skip;
    } ctx_t;

    ctx_t c_d, c_q;

    logic [TMR_W-1:0] tmr;
    logic [PC_W-1:0]  poll_cnt;
    logic             tmr_run;

    logic [DATA_W-1:0] cap_nxt [NUM_GENS];
    logic [DATA_W-1:0] spd_nxt;
    logic [PHY_DW-1:0] phy_set_nxt, phy_clr_nxt;

    // One field-insert per allowed speed limit
    for (genvar g = 0; g < NUM_GENS; g++) begin : g_cap
        lsq_rmw #(.W(DATA_W)) u_rmw (
            .cur      (c_q.shadow),
            .clr_mask (FIELD_MASK),
            .set_bits (DATA_W'(g + 1)),
            .nxt      (cap_nxt[g])
        );
    end

    lsq_rmw #(.W(DATA_W)) u_spd_rmw (
        .cur      (c_q.shadow),
        .clr_mask ('0),
        .set_bits (CHG_MASK),
        .nxt      (spd_nxt)
    );

    lsq_rmw #(.W(PHY_DW)) u_phy_set (
        .cur      (c_q.shadow[PHY_DW-1:0]),
        .clr_mask ('0),
        .set_bits (RX_MASK),
        .nxt      (phy_set_nxt)
    );

    lsq_rmw #(.W(PHY_DW)) u_phy_clr (
        .cur      (c_q.shadow[PHY_DW-1:0]),
        .clr_mask (RX_MASK),
        .set_bits ('0),
        .nxt      (phy_clr_nxt)
    );

    assign tmr_run = (c_q.st == S_LINK1) || (c_q.st == S_LINK2) ||
                     (c_q.st == S_GAP)   || (c_q.st == S_HOLD);

    lsq_counter #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!tmr_run),
        .inc   (1'b1),
        .cnt   (tmr)
    );

    lsq_counter #(.W(PC_W)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (c_q.st == S_IDLE),
        .inc   (c_q.st == S_POLL_CAP),
        .cnt   (poll_cnt)
    );

    always_comb begin
        c_d       = c_q;
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        phy_req   = 1'b0;
        phy_we    = 1'b0;
        phy_wdata = '0;

        case (c_q.st)
            S_IDLE: begin
                if (start) begin
                    c_d.ok    = 1'b0;
                    c_d.fail  = 1'b0;
                    c_d.train = 1'b0;
                    c_d.gen   = '0;
                    c_d.tgt2  = (target_gen == 2'd2);
                    c_d.skip  = skip_chg_wait;
                    c_d.st    = S_CAP_RD;
                end
            end
            S_CAP_RD: begin
                reg_req  = 1'b1;
                reg_addr = ADDR_W'(CAP_ADDR);
                c_d.st   = S_CAP_CAP;
            end
            S_CAP_CAP: begin
                c_d.shadow = reg_rdata;
                c_d.st     = S_CAP_WR;
            end
            S_CAP_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = ADDR_W'(CAP_ADDR);
                reg_wdata = cap_nxt[0];
                c_d.train = 1'b1;
                c_d.st    = S_LINK1;
            end
            S_LINK1: begin
                if (link_up)
                    c_d.st = c_q.tgt2 ? S_CAP2_RD : S_STS_RD;
                else if (tmr == LINK_LAST)
                    c_d.st = S_PHY_RD1;
            end
            S_CAP2_RD: begin
                reg_req  = 1'b1;
                reg_addr = ADDR_W'(CAP_ADDR);
                c_d.st   = S_CAP2_CAP;
            end
            S_CAP2_CAP: begin
                c_d.shadow = reg_rdata;
                c_d.st     = S_CAP2_WR;
            end
            S_CAP2_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = ADDR_W'(CAP_ADDR);
                reg_wdata = cap_nxt[1];
                c_d.st    = S_SPD_RD;
            end
            S_SPD_RD: begin
                reg_req  = 1'b1;
                reg_addr = ADDR_W'(SPD_ADDR);
                c_d.st   = S_SPD_CAP;
            end
            S_SPD_CAP: begin
                c_d.shadow = reg_rdata;
                c_d.st     = S_SPD_WR;
            end
            S_SPD_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = ADDR_W'(SPD_ADDR);
                reg_wdata = spd_nxt;
                c_d.st    = c_q.skip ? S_LINK2 : S_GAP;
            end
            S_GAP: begin
                if (tmr == GAP_LAST)
                    c_d.st = S_POLL_RD;
            end
            S_POLL_RD: begin
                reg_req  = 1'b1;
                reg_addr = ADDR_W'(SPD_ADDR);
                c_d.st   = S_POLL_CAP;
            end
            S_POLL_CAP: begin
                if (!reg_rdata[CHG_BIT])
                    c_d.st = S_LINK2;
                else if (poll_cnt == POLL_LAST)
                    c_d.st = S_PHY_RD1;
                else
                    c_d.st = S_GAP;
            end
            S_LINK2: begin
                if (link_up)
                    c_d.st = S_STS_RD;
                else if (tmr == LINK_LAST)
                    c_d.st = S_PHY_RD1;
            end
            S_STS_RD: begin
                reg_req  = 1'b1;
                reg_addr = ADDR_W'(STS_ADDR);
                c_d.st   = S_STS_CAP;
            end
            S_STS_CAP: begin
                c_d.gen = reg_rdata[GEN_LSB +: 4];
                c_d.ok  = 1'b1;
                c_d.st  = S_IDLE;
            end
            S_PHY_RD1: begin
                phy_req = 1'b1;
                if (phy_ack) begin
                    c_d.shadow = DATA_W'(phy_rdata);
                    c_d.st     = S_PHY_WR1;
                end
            end
            S_PHY_WR1: begin
                phy_req   = 1'b1;
                phy_we    = 1'b1;
                phy_wdata = phy_set_nxt;
                if (phy_ack)
                    c_d.st = S_HOLD;
            end
            S_HOLD: begin
                if (tmr == HOLD_LAST)
                    c_d.st = S_PHY_RD2;
            end
            S_PHY_RD2: begin
                phy_req = 1'b1;
                if (phy_ack) begin
                    c_d.shadow = DATA_W'(phy_rdata);
                    c_d.st     = S_PHY_WR2;
                end
            end
            S_PHY_WR2: begin
                phy_req   = 1'b1;
                phy_we    = 1'b1;
                phy_wdata = phy_clr_nxt;
                if (phy_ack) begin
                    c_d.fail = 1'b1;
                    c_d.st   = S_IDLE;
                end
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st     <= S_IDLE;
            c_q.shadow <= '0;
            c_q.gen    <= '0;
            c_q.ok     <= 1'b0;
            c_q.fail   <= 1'b0;
            c_q.train  <= 1'b0;
            c_q.tgt2   <= 1'b0;
            c_q.skip   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign phy_addr  = PHY_AW'(PHY_RX_REG);
    assign train_en  = c_q.train;
    assign busy      = (c_q.st != S_IDLE);
    assign done_ok   = c_q.ok;
    assign done_fail = c_q.fail;
    assign link_gen  = c_q.gen;
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
    parameter int          PHY_AW  = 16,
    parameter int          PHY_DW  = 16,
    parameter logic [15:0] PHY_REG = 16'h1005
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic              phy_req,
    input logic              phy_we,
    input logic              phy_ack,
    input logic [PHY_AW-1:0] phy_addr,
    input logic [PHY_DW-1:0] phy_wdata,
    input logic              train_en,
    input logic              busy,
    input logic              done_ok,
    input logic              done_fail
);
    p_result_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_fail));

    p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done_ok && !done_fail));

    p_phy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_we) && $stable(phy_wdata)));

    p_phy_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_req |-> (phy_addr == PHY_AW'(PHY_REG)));

    p_fail_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_fail) |-> $past(phy_req && phy_we && phy_ack));

    p_ok_no_phy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> !phy_req);

    p_train_after_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en) |-> $past(reg_req && reg_we));
endmodule

bind link_speed_seq lsq_checker #(
    .PHY_AW  (PHY_AW),
    .PHY_DW  (PHY_DW),
    .PHY_REG (PHY_RX_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_ack   (phy_ack),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .train_en  (train_en),
    .busy      (busy),
    .done_ok   (done_ok),
    .done_fail (done_fail)
);

// File: tb/tb_link_speed_seq.sv
`timescale 1ns/1ps
module tb_link_speed_seq;
    localparam int          LINK_TO  = 20;
    localparam int          POLLS    = 5;
    localparam int          POLL_GAP = 3;
    localparam int          HOLD     = 10;
    localparam logic [11:0] A_CAP    = 12'h010;
    localparam logic [11:0] A_SPD    = 12'h014;
    localparam logic [11:0] A_STS    = 12'h018;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  target_gen = 2'd1;
    logic        skip_chg_wait = 1'b0;
    logic        link_up;
    logic        reg_req, reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic [15:0] phy_rdata;
    logic        phy_ack;
    logic        train_en, busy, done_ok, done_fail;
    logic [3:0]  link_gen;

    // model configuration, driven from the test tasks only
    logic [31:0] cfg_cap, cfg_spd, cfg_sts;
    logic [15:0] cfg_phy;
    int          cfg_clr_delay;
    logic        cfg_link, cfg_drop;

    // model state, driven from the model process only
    logic [31:0] mem_cap, mem_spd, mem_sts;
    logic [15:0] mem_phy;
    logic [31:0] cap_log [4];
    logic [31:0] spd_wr_val;
    logic [15:0] phy_log [2];
    int n_cap_wr, n_spd_wr, n_spd_rd, n_phy_wr, clr_cnt, phy_dly;
    int cyc, ack_cyc, rd2_cyc;
    logic dropped;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    assign link_up = cfg_link && !dropped;

    link_speed_seq #(
        .CAP_ADDR (A_CAP), .SPD_ADDR (A_SPD), .STS_ADDR (A_STS),
        .LINK_TO (LINK_TO), .POLLS (POLLS), .POLL_GAP (POLL_GAP), .HOLD (HOLD)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .target_gen (target_gen),
        .skip_chg_wait (skip_chg_wait), .link_up (link_up),
        .reg_req (reg_req), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .phy_req (phy_req), .phy_we (phy_we), .phy_addr (phy_addr),
        .phy_wdata (phy_wdata), .phy_rdata (phy_rdata), .phy_ack (phy_ack),
        .train_en (train_en), .busy (busy), .done_ok (done_ok),
        .done_fail (done_fail), .link_gen (link_gen)
    );

    // controller and PHY model
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        phy_ack <= 1'b0;
        if (!rst_n) begin
            cyc <= 0; reg_rdata <= '0; phy_rdata <= '0; dropped <= 1'b0;
            n_cap_wr <= 0; n_spd_wr <= 0; n_spd_rd <= 0; n_phy_wr <= 0;
            clr_cnt <= 0; phy_dly <= 0; ack_cyc <= 0; rd2_cyc <= 0;
            mem_cap <= '0; mem_spd <= '0; mem_sts <= '0; mem_phy <= '0;
            spd_wr_val <= '0;
        end else if (start && !busy) begin
            mem_cap <= cfg_cap; mem_spd <= cfg_spd; mem_sts <= cfg_sts; mem_phy <= cfg_phy;
            n_cap_wr <= 0; n_spd_wr <= 0; n_spd_rd <= 0; n_phy_wr <= 0;
            clr_cnt <= 0; phy_dly <= 0; ack_cyc <= 0; rd2_cyc <= 0;
            dropped <= 1'b0; spd_wr_val <= '0;
        end else begin
            if (clr_cnt != 0) begin
                if (clr_cnt == 1) mem_spd[17] <= 1'b0;
                clr_cnt <= clr_cnt - 1;
            end
            if (reg_req) begin
                if (reg_we) begin
                    if (reg_addr == A_CAP) begin
                        mem_cap <= reg_wdata;
                        cap_log[n_cap_wr % 4] <= reg_wdata;
                        n_cap_wr <= n_cap_wr + 1;
                    end else if (reg_addr == A_SPD) begin
                        mem_spd <= reg_wdata;
                        spd_wr_val <= reg_wdata;
                        n_spd_wr <= n_spd_wr + 1;
                        if (reg_wdata[17]) clr_cnt <= cfg_clr_delay;
                        if (cfg_drop) dropped <= 1'b1;
                    end
                end else begin
                    if (reg_addr == A_CAP) reg_rdata <= mem_cap;
                    else if (reg_addr == A_SPD) begin
                        reg_rdata <= mem_spd;
                        n_spd_rd <= n_spd_rd + 1;
                    end else if (reg_addr == A_STS) reg_rdata <= mem_sts;
                    else reg_rdata <= '0;
                end
            end
            if (phy_req && !phy_ack) begin
                if (phy_dly == 2) begin
                    phy_ack <= 1'b1;
                    phy_dly <= 0;
                    if (phy_we) begin
                        mem_phy <= phy_wdata;
                        phy_log[n_phy_wr % 2] <= phy_wdata;
                        n_phy_wr <= n_phy_wr + 1;
                        if (n_phy_wr == 0) ack_cyc <= cyc;
                    end else begin
                        phy_rdata <= mem_phy;
                    end
                end else begin
                    phy_dly <= phy_dly + 1;
                end
                if (!phy_we && n_phy_wr == 1 && rd2_cyc == 0) rd2_cyc <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [31:0] cap, input logic [31:0] spd,
                         input logic [31:0] sts, input int clr_delay,
                         input logic lnk, input logic drop);
        cfg_cap = cap; cfg_spd = spd; cfg_sts = sts; cfg_phy = 16'h0100;
        cfg_clr_delay = clr_delay; cfg_link = lnk; cfg_drop = drop;
    endtask

    // pulse start and wait for a result; returns cycles taken
    task automatic run_seq(input logic [1:0] tgt, input logic skip, output int cycles);
        @(negedge clk);
        target_gen = tgt; skip_chg_wait = skip; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!(done_ok || done_fail) && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
        if (cycles >= 5000) chk(1'b0, "run timeout", 32'(cycles), 32'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !train_en && !done_ok && !done_fail, "R11 flags",
            {busy, train_en, done_ok, done_fail}, 32'd0);
        chk(!reg_req && !phy_req && link_gen == 4'd0, "R11 ports",
            {reg_req, phy_req, link_gen}, 32'd0);
    endtask

    task automatic t_gen1();
        int c;
        setup(32'h0000_00A3, 32'h0000_0103, 32'h0001_0000, 0, 1'b1, 1'b0);
        run_seq(2'd1, 1'b0, c);
        chk(n_cap_wr == 1 && cap_log[0] == 32'h0000_00A1, "R1 cap gen1 rmw",
            cap_log[0], 32'h0000_00A1);
        chk(train_en, "R1 train enabled", 32'(train_en), 32'd1);
        chk(done_ok && !done_fail, "R3 success", {done_ok, done_fail}, 32'd2);
        chk(n_spd_wr == 0, "R3 no speed write", 32'(n_spd_wr), 32'd0);
        chk(link_gen == 4'd1, "R8 gen1", 32'(link_gen), 32'd1);
    endtask

    task automatic t_gen2();
        int c;
        setup(32'h0000_00A3, 32'h0000_0103, 32'h0002_0000, 4, 1'b1, 1'b0);
        run_seq(2'd2, 1'b0, c);
        chk(n_cap_wr == 2 && cap_log[1] == 32'h0000_00A2, "R4 cap gen2 rmw",
            cap_log[1], 32'h0000_00A2);
        chk(n_spd_wr == 1 && spd_wr_val == 32'h0002_0103, "R4 speed change rmw",
            spd_wr_val, 32'h0002_0103);
        chk(n_spd_rd >= 2, "R5 completion polled", 32'(n_spd_rd), 32'd2);
        chk(done_ok && link_gen == 4'd2, "R8 gen2", 32'(link_gen), 32'd2);
    endtask

    task automatic t_poll_timeout();
        int c;
        setup(32'h0000_0001, 32'h0000_0000, 32'h0002_0000, 0, 1'b1, 1'b0);
        run_seq(2'd2, 1'b0, c);
        chk(done_fail && !done_ok, "R5 poll exhaustion fails", {done_ok, done_fail}, 32'd1);
        chk(n_spd_rd == 1 + POLLS, "R5 poll count", 32'(n_spd_rd), 32'(1 + POLLS));
        chk(n_phy_wr == 2 && phy_log[0] == 16'h0128, "R9 override set",
            32'(phy_log[0]), 32'h0128);
        chk(phy_log[1] == 16'h0100, "R9 override cleared", 32'(phy_log[1]), 32'h0100);
        chk(rd2_cyc - ack_cyc >= HOLD, "R9 hold time", 32'(rd2_cyc - ack_cyc), 32'(HOLD));
    endtask

    task automatic t_skip();
        int c;
        setup(32'h0000_0001, 32'h0000_0000, 32'h0001_0000, 0, 1'b1, 1'b0);
        run_seq(2'd2, 1'b1, c);
        chk(done_ok, "R6 skip succeeds", 32'(done_ok), 32'd1);
        chk(n_spd_rd == 1, "R6 no completion polls", 32'(n_spd_rd), 32'd1);
    endtask

    task automatic t_link_timeout();
        int c;
        setup(32'h0000_0002, 32'h0, 32'h0, 0, 1'b0, 1'b0);
        run_seq(2'd2, 1'b0, c);
        chk(done_fail, "R2 link timeout fails", 32'(done_fail), 32'd1);
        chk(n_cap_wr == 1 && n_spd_wr == 0, "R2 no further writes",
            32'(n_cap_wr * 16 + n_spd_wr), 32'h10);
        chk(c >= LINK_TO, "R2 waited full timeout", 32'(c), 32'(LINK_TO));
    endtask

    task automatic t_link2_drop();
        int c;
        setup(32'h0000_0001, 32'h0, 32'h0002_0000, 0, 1'b1, 1'b1);
        run_seq(2'd2, 1'b1, c);
        chk(done_fail && !done_ok, "R7 second link check", {done_ok, done_fail}, 32'd1);
        chk(n_phy_wr == 2, "R7 recovery ran", 32'(n_phy_wr), 32'd2);
    endtask

    task automatic t_busy_start();
        int c;
        setup(32'h0000_0003, 32'h0, 32'h0001_0000, 0, 1'b1, 1'b0);
        @(negedge clk);
        target_gen = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done_fail && !done_ok, "R10 result cleared on start",
            {busy, done_ok, done_fail}, 32'd4);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!(done_ok || done_fail) && c < 5000) begin
            @(negedge clk);
            c++;
        end
        chk(done_ok && n_cap_wr == 1, "R10 start ignored while busy",
            32'(n_cap_wr), 32'd1);
    endtask

    initial begin
        setup(32'h0, 32'h0, 32'h0, 0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_gen1();
        t_gen2();
        t_poll_timeout();
        t_busy_start();
        t_skip();
        t_link_timeout();
        t_link2_drop();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule